// File: doc/BRIEF.md
# Power Management Interrupt Controller

This block gathers six power-related events into one latched flag register, gates them with an enable register, and drives a single interrupt line toward the processor. Four events arrive as single-cycle pulses from analog monitors. These monitors are the input-supply drop comparator, the battery monitor, the supply-delta monitor and the line-sag detector.

The remaining two events come from one asynchronous level input. That input tells whether the switched supply rail is currently fed from the battery. The block synchronizes this level and shows it as a read-only status bit. Its rising edge raises the switchover-to-battery flag, and its falling edge raises the supply-restored flag.

Software uses a byte-wide register port at fixed addresses. It writes the enables and clears flags by writing 0 to them. Writing 1 to a flag leaves it unchanged. Reads are combinational from the address.

Top module: `pm_irq_ctrl`

## Requirements
- R1: After reset the flag and enable registers read 0x00 and `irq_o` is low.
- R2: The enable register sits at address 0xEC, the flag register at 0xF8 and the status register at 0xF4. Bits 7:6 of flag and enable reads are 0. Every status bit except bit 6 reads 0. Any other address reads 0x00.
- R3: The flag and enable bit positions are 0 switchover to battery, 1 supply restored, 2 input-supply drop, 3 battery, 4 supply delta and 5 line sag. A pulse on an event input sets its flag at that clock edge, whatever the enable bit holds.
- R4: A set flag stays set until a write to 0xF8 carries a 0 in that bit position. Such a write clears the flag at that edge.
- R5: Writing 1 to a flag bit has no effect on it.
- R6: When an event pulse and a clearing write reach the same bit at the same edge, the flag ends up set.
- R7: `irq_o` is high exactly when some flag bit and its enable bit are both 1. It follows register updates with no added cycle.
- R8: Status bit 6 is a two-flop synchronized copy of `src_bat_i`. It reads the new value two edges after the input changes, and writes to 0xF4 do not alter it.
- R9: A 0-to-1 change of `src_bat_i` sets flag bit 0 and a 1-to-0 change sets flag bit 1. In both cases the flag is set at the third edge after the change.
- R10: Writing 0xEC loads bits 5:0 into the enable register, and those bits read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe, sampled at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| src_bat_i | input | 1 | Asynchronous level, 1 while the rail is fed from battery |
| vin_low_evt_i | input | 1 | Input-supply drop pulse |
| bat_evt_i | input | 1 | Battery monitor pulse |
| delta_evt_i | input | 1 | Supply-delta pulse |
| sag_evt_i | input | 1 | Line-sag pulse |
| irq_o | output | 1 | Power-management interrupt request |

## Verification
Pulse events and register writes take effect at the edge that samples them. `irq_o` and read data follow combinationally, so the bench drives on the falling edge and samples just after it. The source input needs two edges to reach the status bit and a third to set a switchover or restore flag. The bench reads status and flags after one, two and three edges, which pins that latency exactly. The interrupt check sweeps all 64 enable values against all 16 pulse-flag patterns, using a model mask kept in the bench.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
  localparam int unsigned NUM_EVT     = 6;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned SRC_BIT     = 6;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'hEC;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'hF4;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 8'hF8;

  localparam int unsigned EV_TO_BAT  = 0;
  localparam int unsigned EV_RESTORE = 1;
  localparam int unsigned EV_VIN_LOW = 2;
  localparam int unsigned EV_BAT     = 3;
  localparam int unsigned EV_DELTA   = 4;
  localparam int unsigned EV_SAG     = 5;
endpackage

// File: rtl/pm_src_sync.sv
module pm_src_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_async_i,
  output logic src_o,
  output logic to_bat_o,
  output logic restore_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], src_async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign src_o     = chain_q[STAGES-1];
  assign to_bat_o  = src_o & ~prev_q;
  assign restore_o = ~src_o & prev_q;

  // R9
  to_bat_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_bat_o |=> !to_bat_o);
  // R9
  restore_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> !restore_o);
  // R9
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(to_bat_o && restore_o));
endmodule

// File: rtl/pm_flag_bank.sv
module pm_flag_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    logic clr;
    assign clr = clr_we_i & ~wr_data_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[g]) flag_q <= 1'b1;  // set beats clear
      else if (clr)      flag_q <= 1'b0;
    end
    assign flags_o[g] = flag_q;

    // R6
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flags_o[g]);
    // R4
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_o[g] && !(clr_we_i && !wr_data_i[g]) |=> flags_o[g]);
    // R4
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i && !wr_data_i[g] && !set_i[g] |=> !flags_o[g]);
    // R5
    no_write_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flags_o[g] && !set_i[g] |=> !flags_o[g]);
  end
endmodule

// File: rtl/pm_irq_ctrl.sv
module pm_irq_ctrl
  import pm_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              src_bat_i,
  input  logic              vin_low_evt_i,
  input  logic              bat_evt_i,
  input  logic              delta_evt_i,
  input  logic              sag_evt_i,
  output logic              irq_o
);
  logic               src_sync;
  logic               to_bat, restore;
  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] flags;
  logic [NUM_EVT-1:0] en_q;
  logic               flag_we, en_we;
  logic               unused_wdata;

  pm_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_async_i (src_bat_i),
    .src_o       (src_sync),
    .to_bat_o    (to_bat),
    .restore_o   (restore)
  );

  always_comb begin
    evt             = '0;
    evt[EV_TO_BAT]  = to_bat;
    evt[EV_RESTORE] = restore;
    evt[EV_VIN_LOW] = vin_low_evt_i;
    evt[EV_BAT]     = bat_evt_i;
    evt[EV_DELTA]   = delta_evt_i;
    evt[EV_SAG]     = sag_evt_i;
  end

  assign flag_we      = wr_en_i && (addr_i == ADDR_FLAG);
  assign en_we        = wr_en_i && (addr_i == ADDR_ENABLE);
  assign unused_wdata = ^wdata_i[REG_W-1:NUM_EVT];

  pm_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (evt),
    .clr_we_i  (flag_we),
    .wr_data_i (wdata_i[NUM_EVT-1:0]),
    .flags_o   (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= wdata_i[NUM_EVT-1:0];
  end

  assign irq_o = |(flags & en_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_ENABLE: rdata_o[NUM_EVT-1:0] = en_q;
      ADDR_FLAG:   rdata_o[NUM_EVT-1:0] = flags;
      ADDR_STATUS: rdata_o[SRC_BIT]     = src_sync;
      default:     rdata_o = '0;
    endcase
  end

  // R10
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we |=> en_q == $past(wdata_i[NUM_EVT-1:0]));
  // R10
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we |=> $stable(en_q));
  // R7
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == '0 |-> !irq_o);
  // R9
  to_bat_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_bat |=> flags[EV_TO_BAT]);
endmodule

// File: tb/pm_irq_ctrl_test.sv
module pm_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       src_bat = 1'b0;
  logic       vin_low = 1'b0, bat_e = 1'b0, delta_e = 1'b0, sag_e = 1'b0;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [5:0] mflags = '0;
  logic [5:0] men = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .src_bat_i(src_bat),
    .vin_low_evt_i(vin_low), .bat_evt_i(bat_e), .delta_evt_i(delta_e),
    .sag_evt_i(sag_e), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    {sag_e, delta_e, bat_e, vin_low} = m;
    tick();
    {sag_e, delta_e, bat_e, vin_low} = '0;
  endtask

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(8'hF8, v); chk("R1 flags", v, 8'h00);
    rd(8'hEC, v); chk("R1 enable", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    tick();

    // R2 unmapped and status
    rd(8'h00, v); chk("R2 unmapped 00", v, 8'h00);
    rd(8'hED, v); chk("R2 unmapped ED", v, 8'h00);
    rd(8'hF4, v); chk("R2 status idle", v, 8'h00);

    // R10 enable write/readback, upper bits read 0 (R2)
    for (int e = 0; e < 64; e++) begin
      wr(8'hEC, 8'hC0 | e[7:0]);
      rd(8'hEC, v); chk("R10 R2 enable readback", v, e[7:0]);
    end
    wr(8'hEC, 8'h00);

    // R3 events set flags with enables off, bit positions
    for (int b = 0; b < 4; b++) begin
      pulse(4'(1 << b));
      rd(8'hF8, v); chk("R3 pulse sets flag", v, 8'(1 << (b + 2)));
      chk("R7 no irq when disabled", {7'd0, irq}, 8'h00);
      wr(8'hF8, 8'h00);
    end

    // R5 write 1 has no effect
    wr(8'hF8, 8'hFF);
    rd(8'hF8, v); chk("R5 write ones", v, 8'h00);

    // R4 latching and selective clear
    pulse(4'b1111);
    tick(); tick();
    rd(8'hF8, v); chk("R4 latched", v, 8'h3C);
    wr(8'hF8, 8'hEB);   // clear bits 2 and 4
    rd(8'hF8, v); chk("R4 selective clear", v, 8'h28);
    wr(8'hF8, 8'h00);

    // R6 set beats clear at the same edge
    addr = 8'hF8; wdata = 8'h00; wr_en = 1'b1; sag_e = 1'b1;
    tick();
    wr_en = 1'b0; sag_e = 1'b0;
    rd(8'hF8, v); chk("R6 set wins", v, 8'h20);
    wr(8'hF8, 8'h00);

    // R7 sweep enables against pulse-flag patterns
    for (int p = 0; p < 16; p++) begin
      pulse(4'(p));
      mflags = 6'(p << 2);
      for (int e = 0; e < 64; e++) begin
        wr(8'hEC, e[7:0]);
        men = e[5:0];
        chk("R7 irq", {7'd0, irq}, {7'd0, |(mflags & men)});
      end
      wr(8'hF8, 8'h00);
      chk("R4 cleared", {7'd0, irq}, 8'h00);
    end

    // R8 R9 switchover latency
    wr(8'hEC, 8'h03);
    src_bat = 1'b1;
    tick();
    rd(8'hF4, v); chk("R8 status after 1 edge", v, 8'h00);
    tick();
    rd(8'hF4, v); chk("R8 status after 2 edges", v, 8'h40);
    rd(8'hF8, v); chk("R9 flag not yet", v, 8'h00);
    tick();
    rd(8'hF8, v); chk("R9 switchover flag", v, 8'h01);
    chk("R7 irq switchover", {7'd0, irq}, 8'h01);
    // R8 status not writable
    wr(8'hF4, 8'h00);
    rd(8'hF4, v); chk("R8 status write ignored", v, 8'h40);
    wr(8'hF8, 8'h00);
    src_bat = 1'b0;
    tick(); tick();
    rd(8'hF4, v); chk("R8 status cleared", v, 8'h00);
    rd(8'hF8, v); chk("R9 restore not yet", v, 8'h00);
    tick();
    rd(8'hF8, v); chk("R9 restore flag", v, 8'h02);
    wr(8'hF4, 8'hFF);
    rd(8'hF4, v); chk("R8 status write-1 ignored", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule